// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block tracks the fetch state of every hardware thread in a multithreaded front end. On each clock edge it takes the block and unblock strobes from the four downstream stages (decode, rename, execute, commit), the squash requests from commit and decode, the reorder-buffer-still-squashing indication, and the instruction-cache events. From these it computes one state per thread. It also holds a redirect PC for each thread and drives a single flag that says whether the fetch stage has any work.

The squash sources are ranked. A commit squash beats an ongoing reorder-buffer squash, and that beats a decode squash. A decode squash arriving while the thread is already squashing is dropped. Stall-driven blocking is held off while the thread waits for a cache response, and the stall is applied instead when that response lands. All inputs are sampled at the rising clock edge, and every state, stall flag and PC change is visible right after the edge at which its cause was sampled.

Top module: `fetch_status_ctrl`

## Requirements
- R1: After reset every thread is running (code 0), every PC equals RESET_PC, the next PC equals RESET_PC plus INST_BYTES, all stall flags are clear and no redirect is flagged. State codes are: running 0, idle 1, squashing 2, blocked 3, wait-response 4, wait-retry 5, access-complete 6, trap-pending 7, quiesce-pending 8. Each code sits in threadState[4t+3:4t].
- R2: A block strobe for stage s of thread t sets stallFlags[4t+s], and an unblock strobe clears it. Stage order is decode 0, rename 1, execute 2, commit 3. Block and unblock are never asserted together.
- R3: A commit squash puts the thread in squashing, loads its PC from commitSquashPc, makes the next PC that value plus INST_BYTES, and raises redirectValid for one cycle. It wins over a decode squash in the same cycle.
- R4: With no commit squash, robSquashing keeps or puts the thread in squashing and leaves its PC unchanged.
- R5: A decode squash redirects the thread to decodeSquashPc and puts it in squashing, but only if the thread is not already squashing. Otherwise the thread's PC and redirectValid are unaffected.
- R6: If any stall flag of the thread is set after the update, or contextSwitch is high, and the thread is not waiting for a cache response and no squash applies, the thread goes to blocked.
- R7: A thread in blocked or squashing with no squash and no stall returns to running.
- R8: From running, cacheIssue leads to wait-response and cacheReject leads to wait-retry. From wait-retry, cacheRetryOk leads to wait-response. A squash cancels a wait, and a cacheResp arriving after that has no effect.
- R9: In wait-response, a cacheResp leads to access-complete, or to blocked if the thread is stalled. Stalls never move a thread out of wait-response on their own.
- R10: Access-complete changes to running only in a cycle when fetchSelect picks the thread.
- R11: From running, trapReq leads to trap-pending and quiesceReq leads to quiesce-pending. wakeReq returns thread 0, and only thread 0, from quiesce-pending to running.
- R12: A thread whose threadActive bit is low is held in idle, and its PC ignores squashes. When the bit returns high, the thread resumes in running.
- R13: stageActive is high exactly when some active thread is running, squashing or access-complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| threadActive | input | NUM_THREADS | Thread enabled mask |
| stageBlock | input | 4*NUM_THREADS | Block strobes, bit 4t+s |
| stageUnblock | input | 4*NUM_THREADS | Unblock strobes, bit 4t+s |
| contextSwitch | input | 1 | Global stall for a context switch |
| commitSquash | input | NUM_THREADS | Squash request from commit |
| commitSquashPc | input | NUM_THREADS*PC_W | Commit redirect target per thread |
| robSquashing | input | NUM_THREADS | Reorder buffer still squashing |
| decodeSquash | input | NUM_THREADS | Squash request from decode |
| decodeSquashPc | input | NUM_THREADS*PC_W | Decode redirect target per thread |
| cacheIssue | input | NUM_THREADS | Line request accepted by the cache |
| cacheReject | input | NUM_THREADS | Line request refused, retry needed |
| cacheRetryOk | input | NUM_THREADS | Retried request accepted |
| cacheResp | input | NUM_THREADS | Line data returned |
| fetchSelect | input | NUM_THREADS | Thread picked to fetch this cycle |
| trapReq | input | NUM_THREADS | Trap raised for thread |
| quiesceReq | input | NUM_THREADS | Quiesce instruction seen |
| wakeReq | input | 1 | Wake event for thread 0 |
| threadState | output | 4*NUM_THREADS | State code per thread |
| stallFlags | output | 4*NUM_THREADS | Stall flags, bit 4t+s |
| fetchPc | output | NUM_THREADS*PC_W | Current PC per thread |
| nextPc | output | NUM_THREADS*PC_W | PC plus one instruction |
| redirectValid | output | NUM_THREADS | PC was redirected at the last edge |
| stageActive | output | 1 | Fetch stage has work |

## Verification
The bench sweeps every stage and thread, blocking and unblocking. A design that decoded the wrong stall bit, or tested stale flags, would leave the wrong flag set or the thread stuck in blocked. It then stacks squash sources in the same cycle and on top of an ongoing squash. A wrong priority would show the decode target instead of the commit target, or a spurious redirect while already squashing. Cache corners include a stall raised during wait-response and a response arriving after a squash. A design that blocked too early or accepted stale data would leave wait-response or reach access-complete. Finally, wake is tried on the wrong thread and idle threads receive squashes, which catches a wake or redirect that reaches too far.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int NUM_STAGES = 4;
  localparam int STATE_W = 4;

  typedef enum logic [STATE_W-1:0] {
    ST_RUNNING    = 4'd0,
    ST_IDLE       = 4'd1,
    ST_SQUASHING  = 4'd2,
    ST_BLOCKED    = 4'd3,
    ST_WAIT_RESP  = 4'd4,
    ST_WAIT_RETRY = 4'd5,
    ST_ACC_DONE   = 4'd6,
    ST_TRAP       = 4'd7,
    ST_QUIESCE    = 4'd8
  } fetchState_t;

  typedef struct packed {
    logic loadCommit;
    logic loadDecode;
  } pcStrobe_t;
endpackage

// File: rtl/fsc_datapath.sv
module fsc_datapath #(
  parameter int NUM_THREADS = 2,
  parameter int PC_W = 32,
  parameter int INST_BYTES = 4,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [NUM_THREADS*fsc_pkg::NUM_STAGES-1:0] stageBlock,
  input  logic [NUM_THREADS*fsc_pkg::NUM_STAGES-1:0] stageUnblock,
  input  logic contextSwitch,
  input  logic [NUM_THREADS*PC_W-1:0] commitSquashPc,
  input  logic [NUM_THREADS*PC_W-1:0] decodeSquashPc,
  input  fsc_pkg::pcStrobe_t strobe [NUM_THREADS],
  output logic [NUM_THREADS-1:0] stalled,
  output logic [NUM_THREADS*fsc_pkg::NUM_STAGES-1:0] stallFlags,
  output logic [NUM_THREADS*PC_W-1:0] fetchPc,
  output logic [NUM_THREADS*PC_W-1:0] nextPc,
  output logic [NUM_THREADS-1:0] redirectValid
);
  localparam int NS = fsc_pkg::NUM_STAGES;
  localparam int FLAG_W = NUM_THREADS * NS;

  logic [FLAG_W-1:0] stallQ, stallD;

  assign stallD = (stallQ & ~stageUnblock) | stageBlock;
  assign stallFlags = stallQ;

  always_ff @(posedge clk) begin
    if (!rst_n) stallQ <= '0;
    else        stallQ <= stallD;
  end

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic [PC_W-1:0] pcQ;
    logic redirQ;

    assign stalled[t] = (|stallD[t*NS +: NS]) | contextSwitch;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pcQ <= RESET_PC;
        redirQ <= 1'b0;
      end else begin
        redirQ <= strobe[t].loadCommit | strobe[t].loadDecode;
        if (strobe[t].loadCommit)      pcQ <= commitSquashPc[t*PC_W +: PC_W];
        else if (strobe[t].loadDecode) pcQ <= decodeSquashPc[t*PC_W +: PC_W];
      end
    end

    assign fetchPc[t*PC_W +: PC_W] = pcQ;
    assign nextPc[t*PC_W +: PC_W] = pcQ + PC_W'(INST_BYTES);
    assign redirectValid[t] = redirQ;
  end
endmodule

// File: rtl/fsc_control.sv
module fsc_control #(
  parameter int NUM_THREADS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [NUM_THREADS-1:0] threadActive,
  input  logic [NUM_THREADS-1:0] stalled,
  input  logic [NUM_THREADS-1:0] commitSquash,
  input  logic [NUM_THREADS-1:0] robSquashing,
  input  logic [NUM_THREADS-1:0] decodeSquash,
  input  logic [NUM_THREADS-1:0] cacheIssue,
  input  logic [NUM_THREADS-1:0] cacheReject,
  input  logic [NUM_THREADS-1:0] cacheRetryOk,
  input  logic [NUM_THREADS-1:0] cacheResp,
  input  logic [NUM_THREADS-1:0] fetchSelect,
  input  logic [NUM_THREADS-1:0] trapReq,
  input  logic [NUM_THREADS-1:0] quiesceReq,
  input  logic wakeReq,
  output fsc_pkg::fetchState_t stateQ [NUM_THREADS],
  output fsc_pkg::pcStrobe_t strobe [NUM_THREADS],
  output logic stageActive
);
  import fsc_pkg::*;

  logic [NUM_THREADS-1:0] busy;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    fetchState_t stD;
    pcStrobe_t   stb;
    localparam bit IS_T0 = (t == 0);

    always_comb begin
      stD = stateQ[t];
      stb = '0;
      if (!threadActive[t]) begin
        stD = ST_IDLE;
      end else if (stateQ[t] == ST_IDLE) begin
        stD = ST_RUNNING;
      end else if (commitSquash[t]) begin
        stD = ST_SQUASHING;
        stb.loadCommit = 1'b1;
      end else if (robSquashing[t]) begin
        stD = ST_SQUASHING;
      end else if (decodeSquash[t] && stateQ[t] != ST_SQUASHING) begin
        stD = ST_SQUASHING;
        stb.loadDecode = 1'b1;
      end else if (stalled[t] && stateQ[t] != ST_WAIT_RESP) begin
        stD = ST_BLOCKED;
      end else if (stateQ[t] == ST_BLOCKED || stateQ[t] == ST_SQUASHING) begin
        stD = ST_RUNNING;
      end else begin
        unique case (stateQ[t])
          ST_RUNNING: begin
            if (trapReq[t])          stD = ST_TRAP;
            else if (quiesceReq[t])  stD = ST_QUIESCE;
            else if (cacheReject[t]) stD = ST_WAIT_RETRY;
            else if (cacheIssue[t])  stD = ST_WAIT_RESP;
          end
          ST_WAIT_RETRY: if (cacheRetryOk[t]) stD = ST_WAIT_RESP;
          ST_WAIT_RESP:
            if (cacheResp[t]) stD = stalled[t] ? ST_BLOCKED : ST_ACC_DONE;
          ST_ACC_DONE: if (fetchSelect[t]) stD = ST_RUNNING;
          ST_QUIESCE:  if (IS_T0 && wakeReq) stD = ST_RUNNING;
          default: stD = stateQ[t];
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) stateQ[t] <= ST_RUNNING;
      else        stateQ[t] <= stD;
    end

    assign strobe[t] = stb;
    assign busy[t] = threadActive[t] &&
                     (stateQ[t] == ST_RUNNING || stateQ[t] == ST_SQUASHING ||
                      stateQ[t] == ST_ACC_DONE);
  end

  assign stageActive = |busy;
endmodule

// File: rtl/fetch_status_ctrl.sv
module fetch_status_ctrl #(
  parameter int NUM_THREADS = 2,
  parameter int PC_W = 32,
  parameter int INST_BYTES = 4,
  parameter logic [PC_W-1:0] RESET_PC = 32'h0000_0100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [NUM_THREADS-1:0] threadActive,
  input  logic [NUM_THREADS*4-1:0] stageBlock,
  input  logic [NUM_THREADS*4-1:0] stageUnblock,
  input  logic contextSwitch,
  input  logic [NUM_THREADS-1:0] commitSquash,
  input  logic [NUM_THREADS*PC_W-1:0] commitSquashPc,
  input  logic [NUM_THREADS-1:0] robSquashing,
  input  logic [NUM_THREADS-1:0] decodeSquash,
  input  logic [NUM_THREADS*PC_W-1:0] decodeSquashPc,
  input  logic [NUM_THREADS-1:0] cacheIssue,
  input  logic [NUM_THREADS-1:0] cacheReject,
  input  logic [NUM_THREADS-1:0] cacheRetryOk,
  input  logic [NUM_THREADS-1:0] cacheResp,
  input  logic [NUM_THREADS-1:0] fetchSelect,
  input  logic [NUM_THREADS-1:0] trapReq,
  input  logic [NUM_THREADS-1:0] quiesceReq,
  input  logic wakeReq,
  output logic [NUM_THREADS*4-1:0] threadState,
  output logic [NUM_THREADS*4-1:0] stallFlags,
  output logic [NUM_THREADS*PC_W-1:0] fetchPc,
  output logic [NUM_THREADS*PC_W-1:0] nextPc,
  output logic [NUM_THREADS-1:0] redirectValid,
  output logic stageActive
);
  fsc_pkg::fetchState_t stateQ [NUM_THREADS];
  fsc_pkg::pcStrobe_t   strobe [NUM_THREADS];
  logic [NUM_THREADS-1:0] stalled;

  fsc_control #(.NUM_THREADS(NUM_THREADS)) u_ctrl (
    .clk, .rst_n, .threadActive, .stalled, .commitSquash, .robSquashing,
    .decodeSquash, .cacheIssue, .cacheReject, .cacheRetryOk, .cacheResp,
    .fetchSelect, .trapReq, .quiesceReq, .wakeReq,
    .stateQ, .strobe, .stageActive
  );

  fsc_datapath #(
    .NUM_THREADS(NUM_THREADS), .PC_W(PC_W),
    .INST_BYTES(INST_BYTES), .RESET_PC(RESET_PC)
  ) u_dp (
    .clk, .rst_n, .stageBlock, .stageUnblock, .contextSwitch,
    .commitSquashPc, .decodeSquashPc, .strobe,
    .stalled, .stallFlags, .fetchPc, .nextPc, .redirectValid
  );

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_out
    assign threadState[t*4 +: 4] = stateQ[t];
  end
endmodule

// File: rtl/fsc_checker.sv
module fsc_checker #(
  parameter int NUM_THREADS = 2,
  parameter int PC_W = 32
) (
  input logic clk,
  input logic rst_n,
  input logic [NUM_THREADS-1:0] threadActive,
  input logic [NUM_THREADS*4-1:0] stageBlock,
  input logic [NUM_THREADS*4-1:0] stageUnblock,
  input logic [NUM_THREADS-1:0] commitSquash,
  input logic [NUM_THREADS*PC_W-1:0] commitSquashPc,
  input logic [NUM_THREADS-1:0] robSquashing,
  input logic [NUM_THREADS-1:0] decodeSquash,
  input logic [NUM_THREADS-1:0] cacheResp,
  input logic [NUM_THREADS*4-1:0] threadState,
  input logic [NUM_THREADS*4-1:0] stallFlags,
  input logic [NUM_THREADS*PC_W-1:0] fetchPc,
  input logic [NUM_THREADS-1:0] redirectValid
);
  for (genvar i = 0; i < NUM_THREADS*4; i++) begin : g_flag
    assert_block_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      stageBlock[i] |=> stallFlags[i]);
    assert_unblock_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      stageUnblock[i] |=> !stallFlags[i]);
    assert_no_block_unblock_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(stageBlock[i] && stageUnblock[i]));
  end

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    assert_commit_squash_R3: assert property (@(posedge clk) disable iff (!rst_n)
      threadActive[t] && threadState[t*4 +: 4] != 4'd1 && commitSquash[t]
      |=> threadState[t*4 +: 4] == 4'd2 && redirectValid[t] &&
          fetchPc[t*PC_W +: PC_W] == $past(commitSquashPc[t*PC_W +: PC_W]));
    assert_rob_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      threadActive[t] && threadState[t*4 +: 4] != 4'd1 && !commitSquash[t] &&
      robSquashing[t] |=> threadState[t*4 +: 4] == 4'd2 && !redirectValid[t]);
    assert_decode_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
      threadActive[t] && threadState[t*4 +: 4] == 4'd2 && !commitSquash[t] &&
      decodeSquash[t] |=> !redirectValid[t]);
    assert_wait_resp_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      threadActive[t] && threadState[t*4 +: 4] == 4'd4 && !commitSquash[t] &&
      !robSquashing[t] && !decodeSquash[t] && !cacheResp[t]
      |=> threadState[t*4 +: 4] == 4'd4);
    assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !threadActive[t] |=> threadState[t*4 +: 4] == 4'd1 &&
                           $stable(fetchPc[t*PC_W +: PC_W]));
  end
endmodule

bind fetch_status_ctrl fsc_checker #(.NUM_THREADS(NUM_THREADS), .PC_W(PC_W)) u_chk (.*);

// File: tb/fetch_status_ctrl_bench.sv
module fetch_status_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int T = 2;
  localparam int PW = 32;
  localparam logic [31:0] RPC = 32'h0000_0100;

  localparam logic [3:0] S_RUN = 0, S_IDLE = 1, S_SQ = 2, S_BLK = 3, S_WRESP = 4,
                         S_WRETRY = 5, S_DONE = 6, S_TRAP = 7, S_QUI = 8;

  logic clk = 0, rst_n = 0;
  logic [T-1:0] threadActive;
  logic [T*4-1:0] stageBlock, stageUnblock;
  logic contextSwitch, wakeReq;
  logic [T-1:0] commitSquash, robSquashing, decodeSquash, cacheIssue, cacheReject;
  logic [T-1:0] cacheRetryOk, cacheResp, fetchSelect, trapReq, quiesceReq;
  logic [T*PW-1:0] commitSquashPc, decodeSquashPc;
  logic [T*4-1:0] threadState, stallFlags;
  logic [T*PW-1:0] fetchPc, nextPc;
  logic [T-1:0] redirectValid;
  logic stageActive;

  int nChecks = 0, nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_status_ctrl u_fetch_status_ctrl (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] st(int t);
    return threadState[t*4 +: 4];
  endfunction

  function automatic logic [31:0] pcOf(int t);
    return fetchPc[t*PW +: PW];
  endfunction

  task automatic clr();
    stageBlock = '0; stageUnblock = '0; contextSwitch = 0; wakeReq = 0;
    commitSquash = '0; robSquashing = '0; decodeSquash = '0;
    cacheIssue = '0; cacheReject = '0; cacheRetryOk = '0; cacheResp = '0;
    fetchSelect = '0; trapReq = '0; quiesceReq = '0;
  endtask

  task automatic tick();
    @(posedge clk); #1; clr();
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    threadActive = '1; commitSquashPc = '0; decodeSquashPc = '0; clr();
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    for (int t = 0; t < T; t++) begin
      chk("R1 state", st(t), S_RUN);
      chk("R1 pc", pcOf(t), RPC);
      chk("R1 nextpc", nextPc[t*PW +: PW], RPC + 4);
    end
    chk("R1 flags", stallFlags, 0);
    chk("R1 redirect", redirectValid, 0);
    chk("R13 active", stageActive, 1);

    // R2/R6/R7 sweep over every stage and thread
    for (int t = 0; t < T; t++) begin
      for (int s = 0; s < 4; s++) begin
        stageBlock[t*4+s] = 1; tick();
        chk("R2 set", stallFlags, 32'(1) << (t*4+s));
        chk("R6 blocked", st(t), S_BLK);
        chk("R6 other", st(1-t), S_RUN);
        tick();
        chk("R6 hold", st(t), S_BLK);
        stageUnblock[t*4+s] = 1; tick();
        chk("R2 clear", stallFlags, 0);
        chk("R7 resume", st(t), S_RUN);
      end
    end
    contextSwitch = 1; tick();
    chk("R6 ctxsw t0", st(0), S_BLK);
    chk("R6 ctxsw t1", st(1), S_BLK);
    chk("R13 all blocked", stageActive, 0);
    tick();
    chk("R7 ctxsw resume", st(0), S_RUN);

    // R3 commit squash beats decode squash
    commitSquash[0] = 1; commitSquashPc[0 +: PW] = 32'h1000;
    decodeSquash[0] = 1; decodeSquashPc[0 +: PW] = 32'h2000;
    tick();
    chk("R3 state", st(0), S_SQ);
    chk("R3 pc", pcOf(0), 32'h1000);
    chk("R3 nextpc", nextPc[0 +: PW], 32'h1004);
    chk("R3 redirect", redirectValid, 2'b01);
    chk("R3 other pc", pcOf(1), RPC);
    // R4 rob squashing holds, R5 decode ignored while squashing
    robSquashing[0] = 1; decodeSquash[0] = 1; decodeSquashPc[0 +: PW] = 32'h3000;
    tick();
    chk("R4 state", st(0), S_SQ);
    chk("R5 pc kept", pcOf(0), 32'h1000);
    chk("R5 no redirect", redirectValid, 0);
    decodeSquash[0] = 1; tick();
    chk("R5 ignored again", pcOf(0), 32'h1000);
    tick();
    chk("R7 after squash", st(0), S_RUN);
    // R5 decode squash from running
    decodeSquash[1] = 1; decodeSquashPc[PW +: PW] = 32'h4440; tick();
    chk("R5 state", st(1), S_SQ);
    chk("R5 pc", pcOf(1), 32'h4440);
    chk("R5 redirect", redirectValid, 2'b10);
    tick();

    // R8/R9/R10 cache events
    cacheIssue[0] = 1; tick();
    chk("R8 issue", st(0), S_WRESP);
    stageBlock[1] = 1; tick();
    chk("R9 no block in wait", st(0), S_WRESP);
    chk("R2 flag in wait", stallFlags[1], 1);
    cacheResp[0] = 1; tick();
    chk("R9 resp stalled", st(0), S_BLK);
    stageUnblock[1] = 1; tick();
    chk("R7 unblock", st(0), S_RUN);
    cacheIssue[0] = 1; tick();
    cacheResp[0] = 1; tick();
    chk("R9 resp done", st(0), S_DONE);
    chk("R13 done active", stageActive, 1);
    fetchSelect[1] = 1; tick();
    chk("R10 wrong select", st(0), S_DONE);
    fetchSelect[0] = 1; tick();
    chk("R10 select", st(0), S_RUN);
    cacheReject[0] = 1; tick();
    chk("R8 reject", st(0), S_WRETRY);
    cacheResp[0] = 1; tick();
    chk("R8 retry ignores resp", st(0), S_WRETRY);
    cacheRetryOk[0] = 1; tick();
    chk("R8 retry ok", st(0), S_WRESP);
    commitSquash[0] = 1; commitSquashPc[0 +: PW] = 32'h5000; tick();
    chk("R8 squash cancels", st(0), S_SQ);
    cacheResp[0] = 1; tick();
    chk("R8 stale resp", st(0), S_RUN);

    // R11 trap and quiesce
    trapReq[0] = 1; quiesceReq[0] = 1; tick();
    chk("R11 trap", st(0), S_TRAP);
    quiesceReq[1] = 1; tick();
    chk("R11 quiesce", st(1), S_QUI);
    chk("R13 none active", stageActive, 0);
    wakeReq = 1; tick();
    chk("R11 wake not t1", st(1), S_QUI);
    chk("R11 wake not trap", st(0), S_TRAP);
    commitSquash = 2'b11; commitSquashPc = {32'h6000, 32'h7000}; tick();
    tick();
    chk("R11 exit t0", st(0), S_RUN);
    quiesceReq[0] = 1; tick();
    chk("R11 quiesce t0", st(0), S_QUI);
    wakeReq = 1; tick();
    chk("R11 wake t0", st(0), S_RUN);
    chk("R11 t1 resumed", st(1), S_RUN);

    // R12 idle
    threadActive[1] = 0; tick();
    chk("R12 idle", st(1), S_IDLE);
    commitSquash[1] = 1; commitSquashPc[PW +: PW] = 32'h9990; tick();
    chk("R12 pc kept", pcOf(1), 32'h6000);
    chk("R12 no redirect", redirectValid, 0);
    trapReq[0] = 1; tick();
    chk("R13 trap plus idle", stageActive, 0);
    threadActive[1] = 1; #1;
    chk("R13 idle masked", stageActive, 0);
    tick();
    chk("R12 resume", st(1), S_RUN);
    chk("R13 resumed", stageActive, 1);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule